// File: doc/BRIEF.md
# Unified Divide / Square-Root / Reciprocal-Root Unit

This block computes, one result bit per clock, either an unsigned fixed-point quotient, a square root, or a reciprocal square root, each paired with an exact remainder. It is driven by a single start handshake: the operands and a 2-bit operation code are captured when `start_valid` and `start_ready` are both high, the unit then spends W cycles on the recurrence, and it raises `done_o` for one cycle when the result and remainder are ready.

All three operations share one recurrence. A left-hand side is set from the operands when the operation is accepted. A right-hand side starts at zero and grows as result bits are accepted. Each cycle the next result bit, from MSB to LSB, is tried: the right-hand side is recomputed for the trial value using only adds and shifts of a carried result-times-operand term, and the bit is kept when the trial does not exceed the left side. The remainder is the left side minus the final right side.

The numbers are fixed point. With base width W and fraction width F, `operand_i` and `result_o` carry F fraction bits, `dividend_i` is W+F bits wide with 2F fraction bits, and the remainder is 3W bits wide with 3F fraction bits. In the requirements below every value is read as the plain unsigned integer on its pins.

Top module: `dru_core`

## Requirements
- R1: With op code 0 (divide) and operand d != 0, the result is the largest q < 2^W with q*d <= dividend, and the remainder is (dividend - q*d) * 2^F.
- R2: With op code 1 (square root) and operand s, the result is the largest r < 2^W with r*r <= s * 2^F, and the remainder is (s * 2^F - r*r) * 2^F.
- R3: With op code 2 (reciprocal root) and operand s != 0, the result is the largest r < 2^W with r*r*s <= 2^(3F), and the remainder is 2^(3F) - r*r*s. The remainder is never negative.
- R4: A zero operand gives an all-ones result for op code 0 (remainder dividend * 2^F) and for op code 2 (remainder 2^(3F)).
- R5: Op code 3 gives the same result and remainder as op code 2.
- R6: `done_o` rises in the cycle after the W-th rising edge that follows the accepting edge, and stays high for exactly one cycle.
- R7: `start_ready` is low from the accepting edge until `done_o` is raised. A start request made in that window is ignored and does not change the result.
- R8: The carried result-times-operand term equals the current partial result times the captured operand in every cycle.
- R9: After reset `done_o` is 0, `start_ready` is 1, and `result_o` and `rem_o` are 0.
- R10: `result_o` and `rem_o` keep their values after `done_o` until the next operation is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_valid | input | 1 | Request to start an operation |
| start_ready | output | 1 | Unit idle and able to accept a start |
| op_i | input | 2 | 0 divide, 1 square root, 2 or 3 reciprocal square root |
| dividend_i | input | W+F | Dividend, 2F fraction bits (divide only) |
| operand_i | input | W | Divisor or radicand, F fraction bits |
| done_o | output | 1 | One-cycle pulse when the result is ready |
| result_o | output | W | Quotient or root, F fraction bits |
| rem_o | output | 3W | Remainder, 3F fraction bits |

## Verification
The assertions check on every cycle that the carried product term matches the partial result times the operand, that the right-hand side never exceeds the left side (so the remainder cannot wrap), that the captured operation stays fixed while a run is in progress, and that `done_o` is a single-cycle pulse seen only while the unit is ready. The numerical results can only be shown by the bench's scenarios. These compare all three operations against an integer search model on edge operands (zero, one, all ones, exact squares) and random operands, and they also measure the W+1 cycle latency and check that a start raised mid-run is ignored.

// File: rtl/dru_pkg.sv
package dru_pkg;
   typedef enum logic [1:0] {
      DRU_DIV   = 2'd0,
      DRU_SQRT  = 2'd1,
      DRU_RSQRT = 2'd2,
      DRU_RSQ_B = 2'd3
   } dru_op_e;
endpackage

// File: rtl/dru_setup.sv
module dru_setup
   import dru_pkg::*;
#(
   parameter int W = 8,
   parameter int F = 4
) (
   input  dru_op_e          op,
   input  logic [W+F-1:0]   dividend,
   input  logic [W-1:0]     operand,
   output logic [3*W-1:0]   lhs
);
   localparam int LW = 3 * W;

   always_comb begin
      unique case (op)
         DRU_DIV:  lhs = LW'(dividend) << F;
         DRU_SQRT: lhs = LW'(operand) << (2 * F);
         default:  lhs = LW'(1) << (3 * F);
      endcase
   end
endmodule

// File: rtl/dru_step.sv
module dru_step
   import dru_pkg::*;
#(
   parameter int W = 8,
   parameter int F = 4
) (
   input  dru_op_e                  op,
   input  logic [W-1:0]             operand,
   input  logic [$clog2(W)-1:0]     idx,
   input  logic [W-1:0]             q,
   input  logic [2*W-1:0]           qd,
   input  logic [3*W-1:0]           rhs,
   input  logic [3*W-1:0]           lhs,
   output logic                     take,
   output logic [W-1:0]             q_next,
   output logic [2*W-1:0]           qd_next,
   output logic [3*W-1:0]           rhs_next
);
   localparam int EW = 3 * W + 2;
   localparam int PW = 2 * W;

   logic [EW-1:0] inc;
   logic [EW-1:0] trial;
   logic [W-1:0]  bit_v;
   int unsigned   sh;

   always_comb begin
      sh    = 32'(idx);
      bit_v = W'(1) << sh;
      unique case (op)
         DRU_DIV:  inc = EW'(operand) << (sh + F);
         DRU_SQRT: inc = ((EW'(q) << (sh + 1)) + (EW'(1) << (2 * sh))) << F;
         default:  inc = (EW'(qd) << (sh + 1)) + (EW'(operand) << (2 * sh));
      endcase
      trial    = EW'(rhs) + inc;
      take     = (trial <= EW'(lhs));
      q_next   = take ? (q | bit_v) : q;
      qd_next  = take ? (qd + (PW'(operand) << sh)) : qd;
      rhs_next = take ? trial[3*W-1:0] : rhs;
   end
endmodule

// File: rtl/dru_core.sv
module dru_core
   import dru_pkg::*;
#(
   parameter int W = 8,
   parameter int F = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start_valid,
   output logic               start_ready,
   input  logic [1:0]         op_i,
   input  logic [W+F-1:0]     dividend_i,
   input  logic [W-1:0]       operand_i,
   output logic               done_o,
   output logic [W-1:0]       result_o,
   output logic [3*W-1:0]     rem_o
);
   localparam int IW = $clog2(W);
   localparam int PW = 2 * W;
   localparam int LW = 3 * W;

   if (W < 2) begin : g_bad_width
      $error("dru_core: W must be at least 2");
   end
   if (F >= W) begin : g_bad_frac
      $error("dru_core: F must be below W");
   end

   dru_op_e         op_q;
   logic [W-1:0]    opnd_q;
   logic [LW-1:0]   lhs_q, rhs_q;
   logic [W-1:0]    q_q;
   logic [PW-1:0]   qd_q;
   logic [IW-1:0]   idx_q;
   logic            busy_q, done_q;

   logic [LW-1:0]   setup_lhs;
   logic            take;
   logic [W-1:0]    q_nx;
   logic [PW-1:0]   qd_nx;
   logic [LW-1:0]   rhs_nx;
   logic            accept;

   assign start_ready = ~busy_q;
   assign accept      = start_valid & ~busy_q;

   dru_setup #(.W(W), .F(F)) i_setup (
      .op       (dru_op_e'(op_i)),
      .dividend (dividend_i),
      .operand  (operand_i),
      .lhs      (setup_lhs)
   );

   dru_step #(.W(W), .F(F)) i_step (
      .op       (op_q),
      .operand  (opnd_q),
      .idx      (idx_q),
      .q        (q_q),
      .qd       (qd_q),
      .rhs      (rhs_q),
      .lhs      (lhs_q),
      .take     (take),
      .q_next   (q_nx),
      .qd_next  (qd_nx),
      .rhs_next (rhs_nx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op_q   <= DRU_DIV;
         opnd_q <= '0;
         lhs_q  <= '0;
         rhs_q  <= '0;
         q_q    <= '0;
         qd_q   <= '0;
         idx_q  <= '0;
         busy_q <= 1'b0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (accept) begin
            op_q   <= dru_op_e'(op_i);
            opnd_q <= operand_i;
            lhs_q  <= setup_lhs;
            rhs_q  <= '0;
            q_q    <= '0;
            qd_q   <= '0;
            idx_q  <= IW'(W - 1);
            busy_q <= 1'b1;
         end else if (busy_q) begin
            q_q   <= q_nx;
            qd_q  <= qd_nx;
            rhs_q <= rhs_nx;
            if (idx_q == '0) begin
               busy_q <= 1'b0;
               done_q <= 1'b1;
            end else begin
               idx_q <= idx_q - 1'b1;
            end
         end
      end
   end

   assign done_o   = done_q;
   assign result_o = q_q;
   assign rem_o    = lhs_q - rhs_q;

   // R8: carried product term tracks the partial result
   a_r8_product_carried: assert property (@(posedge clk) disable iff (!rst_n)
      qd_q == PW'(q_q) * PW'(opnd_q));

   // R3: right side never overtakes left side, remainder cannot wrap
   a_r3_rem_nonneg: assert property (@(posedge clk) disable iff (!rst_n)
      rhs_q <= lhs_q);

   // R6: done is a single-cycle pulse
   a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R6/R7: done only appears with the unit idle
   a_r6_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> start_ready);

   // R7: captured operation frozen while a run is in progress
   a_r7_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && idx_q != '0) |=> ($stable(op_q) && $stable(opnd_q) && $stable(lhs_q)));
endmodule

// File: tb/test_dru_core.sv
module test_dru_core;
   localparam int W = 8;
   localparam int F = 4;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               start_valid = 1'b0;
   logic               start_ready;
   logic [1:0]         op_i = 2'd0;
   logic [W+F-1:0]     dividend_i = '0;
   logic [W-1:0]       operand_i = '0;
   logic               done_o;
   logic [W-1:0]       result_o;
   logic [3*W-1:0]     rem_o;

   int checks = 0;
   int fails  = 0;
   bit finished = 0;

   always #4 clk = ~clk;

   dru_core #(.W(W), .F(F)) i_dru_core (
      .clk, .rst_n, .start_valid, .start_ready, .op_i,
      .dividend_i, .operand_i, .done_o, .result_o, .rem_o
   );

   task automatic check(input string req, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic longint ref_q(input int op, input longint dvd, input longint s);
      longint best = 0;
      for (longint r = 0; r < (1 << W); r++) begin
         if (op == 0 && r * s <= dvd) best = r;
         if (op == 1 && r * r <= s * (1 << F)) best = r;
         if (op >= 2 && r * r * s <= (1 << (3 * F))) best = r;
      end
      return best;
   endfunction

   function automatic longint ref_rem(input int op, input longint dvd, input longint s);
      longint r = ref_q(op, dvd, s);
      if (op == 0) return (dvd - r * s) * (1 << F);
      if (op == 1) return (s * (1 << F) - r * r) * (1 << F);
      return (1 << (3 * F)) - r * r * s;
   endfunction

   // accepts one operation, waits for done, returns latency in negedges
   task automatic launch(input int op, input longint dvd, input longint s,
                         input bit poke_busy, output int lat);
      @(negedge clk);
      op_i = 2'(op); dividend_i = (W+F)'(dvd); operand_i = W'(s);
      start_valid = 1'b1;
      @(negedge clk);
      start_valid = 1'b0;
      lat = 1;
      if (poke_busy) begin
         check("R7 ready low while busy", start_ready, 0);
         op_i = 2'd1; dividend_i = '1; operand_i = 8'd7;
         start_valid = 1'b1;
         repeat (3) begin @(negedge clk); lat++; end
         check("R7 ready still low", start_ready, 0);
         start_valid = 1'b0;
      end
      while (!done_o && lat < 50) begin @(negedge clk); lat++; end
   endtask

   task automatic run_case(input string req, input int op, input longint dvd, input longint s);
      int lat;
      launch(op, dvd, s, 1'b0, lat);
      check({req, " result"}, result_o, ref_q(op, dvd, s));
      check({req, " remainder"}, rem_o, ref_rem(op, dvd, s));
   endtask

   task automatic t_reset;
      check("R9 done after reset", done_o, 0);
      check("R9 ready after reset", start_ready, 1);
      check("R9 result after reset", result_o, 0);
      check("R9 rem after reset", rem_o, 0);
   endtask

   task automatic t_divide;
      run_case("R1 div 4095/1", 0, 4095, 1);
      run_case("R1 div 100/7", 0, 100, 7);
      run_case("R1 div 0/255", 0, 0, 255);
      run_case("R1 div 4095/255", 0, 4095, 255);
      for (int k = 0; k < 25; k++)
         run_case("R1 div random", 0, longint'($urandom_range(4095, 0)), longint'($urandom_range(255, 1)));
   endtask

   task automatic t_sqrt;
      run_case("R2 sqrt 0", 1, 0, 0);
      run_case("R2 sqrt 16", 1, 0, 16);
      run_case("R2 sqrt 255", 1, 0, 255);
      run_case("R2 sqrt 64", 1, 0, 64);
      for (int k = 0; k < 20; k++)
         run_case("R2 sqrt random", 1, 0, longint'($urandom_range(255, 0)));
   endtask

   task automatic t_rsqrt;
      run_case("R3 rsqrt 16", 2, 0, 16);
      run_case("R3 rsqrt 1", 2, 0, 1);
      run_case("R3 rsqrt 255", 2, 0, 255);
      run_case("R3 rsqrt 64", 2, 0, 64);
      for (int k = 0; k < 20; k++)
         run_case("R3 rsqrt random", 2, 0, longint'($urandom_range(255, 1)));
   endtask

   task automatic t_zero;
      run_case("R4 div by zero", 0, 1234, 0);
      check("R4 div by zero all ones", result_o, 255);
      run_case("R4 rsqrt zero", 2, 0, 0);
      check("R4 rsqrt zero all ones", result_o, 255);
   endtask

   task automatic t_code3;
      for (int s = 1; s < 256; s += 37) begin
         run_case("R5 code 3", 3, 0, s);
         check("R5 code 3 matches code 2", result_o, ref_q(2, 0, s));
      end
   endtask

   task automatic t_timing;
      int lat;
      launch(0, 200, 9, 1'b0, lat);
      check("R6 latency", lat, W + 1);
      @(negedge clk);
      check("R6 done one cycle", done_o, 0);
      check("R10 result held", result_o, ref_q(0, 200, 9));
      repeat (4) @(negedge clk);
      check("R10 rem held", rem_o, ref_rem(0, 200, 9));
      check("R10 result still held", result_o, ref_q(0, 200, 9));
   endtask

   task automatic t_busy;
      int lat;
      launch(1, 0, 200, 1'b1, lat);
      check("R7 latency with mid-run start", lat, W + 1);
      check("R7 result unaffected", result_o, ref_q(1, 0, 200));
      check("R7 rem unaffected", rem_o, ref_rem(1, 0, 200));
      @(negedge clk);
      check("R7 no second run", start_ready, 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_divide();
      t_sqrt();
      t_rsqrt();
      t_zero();
      t_code3();
      t_timing();
      t_busy();
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule